// File: doc/BRIEF.md
# Unaligned Partial Store Unit

This block takes one store-left or store-right request and turns it into a single write beat on an eight-byte-wide aligned memory port. A request carries the register value, a byte address, the operation (left or right), the operand size (word or doubleword) and the byte order. The block works out which bytes of the register belong in memory and which memory lanes they land on. It then presents an aligned address, a byte-enable mask and lane-placed write data.

Every byte that one of these stores touches lies inside one aligned word or doubleword, so one beat always covers it. The computation is combinational. A parameter selects whether the result goes straight to the outputs or through one register stage. A load/store pipeline would use the block between address generation and the data cache write port.

Top module: `partial_store_unit`

## Requirements
- R1: The lane index is taken from the address. For a word it is addr[1:0] when big_endian=1 and addr[1:0] XOR 3 when big_endian=0. For a doubleword it is addr[2:0] when big_endian=1 and addr[2:0] XOR 7 when big_endian=0.
- R2: A store-left (op_right=0) writes the most significant register byte at the request address, then the next lower register bytes at successive addresses. The byte count is N minus the lane index, where N is 4 for a word (dword=0) and 8 for a doubleword (dword=1).
- R3: A store-right (op_right=1) writes the least significant register byte at the request address, then the next higher register bytes at successive addresses. The byte count is the lane index plus one.
- R4: For a store-left, successive bytes go to increasing addresses when big_endian=1 and to decreasing addresses when big_endian=0. A store-right steps in the opposite direction.
- R5: Word operations use only data_in[31:0]. They enable only lanes inside the four-byte half selected by addr[2]: lanes 0..3 when addr[2]=0 and lanes 4..7 when addr[2]=1.
- R6: out_addr equals the request address with bits [2:0] cleared. Lane k stands for byte address out_addr+k and carries out_data[8k+7:8k], with out_be[k] as its enable.
- R7: Every lane whose enable is 0 drives zero data.
- R8: A store-left whose lane index is 0, and a store-right whose lane index is N-1, each enable all N bytes of the aligned word or doubleword.
- R9: With REG_OUT=1 the result appears one clock after the request. out_valid repeats in_valid with the same one-cycle delay. When out_valid is 0, out_addr, out_be and out_data are all zero.
- R10: While reset is asserted, out_valid is 0 and out_be is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_right | input | 1 | 1 = store-right, 0 = store-left |
| in_dword | input | 1 | 1 = doubleword, 0 = word |
| in_big | input | 1 | 1 = big-endian, 0 = little-endian |
| in_addr | input | ADDR_W | Byte address of the request |
| in_data | input | 64 | Register value (word uses bits 31:0) |
| out_valid | output | 1 | Write beat present |
| out_addr | output | ADDR_W | Doubleword-aligned write address |
| out_be | output | 8 | Byte enables, one per lane |
| out_data | output | 64 | Lane-placed write data |

## Verification
Two things can happen in the same cycle: a new request enters the compute logic while the previous result is still being presented. The bench provokes this by driving requests back to back with no idle cycle, mixing store-left and store-right, both sizes and both byte orders. A scoreboard predicts every beat from a byte-at-a-time model that walks the address one step at a time. Requests are also interleaved with idle cycles to show that an empty slot presents an all-zero beat and never repeats the previous one.

// File: rtl/psu_pkg.sv
package psu_pkg;

    localparam int LANES   = 8;
    localparam int LANE_W  = 3;
    localparam int DATA_W  = LANES * 8;

    // control fields shared by every lane of one request
    typedef struct packed {
        logic              right;
        logic              dword;
        logic              big;
        logic              half;      // addr[2], word half in use
        logic [LANE_W-1:0] unit_off;  // byte offset inside the operand unit
        logic [LANE_W-1:0] top_byte;  // N-1
    } psu_ctl_t;

endpackage

// File: rtl/psu_decode.sv
module psu_decode
    import psu_pkg::*;
(
    input  logic              right,
    input  logic              dword,
    input  logic              big,
    input  logic [LANE_W-1:0] addr_lo,
    output psu_ctl_t          ctl
);

    always_comb begin
        ctl.right    = right;
        ctl.dword    = dword;
        ctl.big      = big;
        ctl.half     = addr_lo[2];
        ctl.unit_off = dword ? addr_lo : {1'b0, addr_lo[1:0]};
        ctl.top_byte = dword ? 3'd7 : 3'd3;
    end

endmodule

// File: rtl/psu_byte_lane.sv
module psu_byte_lane
    import psu_pkg::*;
#(
    parameter int LANE = 0
) (
    input  psu_ctl_t          ctl,
    input  logic [DATA_W-1:0] reg_data,
    output logic              en,
    output logic [7:0]        byte_out
);

    localparam logic [LANE_W-1:0] LANE_IDX = LANE_W'(LANE);

    logic [LANE_W-1:0] pos;
    logic              in_unit;
    logic              up_side;   // lane at or above the offset
    logic              dn_side;   // lane at or below the offset
    logic              fill_up;   // bytes placed at increasing addresses
    logic [LANE_W-1:0] src;

    always_comb begin
        pos     = ctl.dword ? LANE_IDX : {1'b0, LANE_IDX[1:0]};
        in_unit = ctl.dword || (LANE_IDX[2] == ctl.half);
        up_side = pos >= ctl.unit_off;
        dn_side = pos <= ctl.unit_off;
        // left+big and right+little fill upward; the others fill downward
        fill_up = ctl.big ^ ctl.right;

        if (ctl.right) begin
            src = fill_up ? (pos - ctl.unit_off) : (ctl.unit_off - pos);
        end else begin
            src = fill_up ? (ctl.top_byte - (pos - ctl.unit_off))
                          : (ctl.top_byte - (ctl.unit_off - pos));
        end

        en       = in_unit && (fill_up ? up_side : dn_side);
        byte_out = en ? reg_data[{src, 3'b000} +: 8] : 8'h00;
    end

endmodule

// File: rtl/partial_store_unit.sv
module partial_store_unit
    import psu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_right,
    input  logic              in_dword,
    input  logic              in_big,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [63:0]       in_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [7:0]        out_be,
    output logic [63:0]       out_data
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } beat_t;

    psu_ctl_t          ctl;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] lane_data;
    beat_t             beat_d;
    beat_t             beat_q;

    psu_decode u_decode (
        .right   (in_right),
        .dword   (in_dword),
        .big     (in_big),
        .addr_lo (in_addr[LANE_W-1:0]),
        .ctl     (ctl)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        psu_byte_lane #(.LANE(g)) u_lane (
            .ctl      (ctl),
            .reg_data (in_data),
            .en       (lane_en[g]),
            .byte_out (lane_data[g*8 +: 8])
        );
    end

    always_comb begin
        beat_d = '0;
        if (in_valid) begin
            beat_d.valid = 1'b1;
            beat_d.addr  = {in_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            beat_d.be    = lane_en;
            beat_d.data  = lane_data;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) beat_q <= '0;
            else        beat_q <= beat_d;
        end
    end else begin : g_comb
        always_comb beat_q = beat_d;
    end

    assign out_valid = beat_q.valid;
    assign out_addr  = beat_q.addr;
    assign out_be    = beat_q.be;
    assign out_data  = beat_q.data;

endmodule

// File: rtl/partial_store_unit_chk.sv
module partial_store_unit_chk #(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_dword,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [7:0]        out_be,
    input logic [63:0]       out_data
);

    logic [63:0] off_bits;
    for (genvar g = 0; g < 8; g++) begin : g_exp
        assign off_bits[g*8 +: 8] = {8{~out_be[g]}};
    end

    assert_addr_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr[2:0] == 3'b000);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_be == 8'h00 && out_data == 64'h0));

    assert_zero_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data & off_bits) == 64'h0);

    assert_some_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_be != 8'h00);

    if (REG_OUT) begin : g_seq
        assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        assert_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        assert_word_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_dword) |=> (out_be[7:4] == 4'h0 || out_be[3:0] == 4'h0));
    end else begin : g_cmb
        assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid == out_valid);
        assert_word_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_dword) |-> (out_be[7:4] == 4'h0 || out_be[3:0] == 4'h0));
    end

endmodule

bind partial_store_unit partial_store_unit_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dword  (in_dword),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_be    (out_be),
    .out_data  (out_data)
);

// File: tb/partial_store_unit_test.sv
`timescale 1ns/1ps
module partial_store_unit_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_right = 1'b0, in_dword = 1'b0, in_big = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [63:0]   in_data = '0;
    logic          out_valid;
    logic [AW-1:0] out_addr;
    logic [7:0]    out_be;
    logic [63:0]   out_data;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [7:0]    be;
        logic [63:0]   data;
        string         tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    partial_store_unit #(.ADDR_W(AW), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_right(in_right),
        .in_dword(in_dword), .in_big(in_big), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_addr(out_addr), .out_be(out_be), .out_data(out_data)
    );

    // byte-at-a-time reference: walk the address one step per byte (R1..R5, R8)
    function automatic exp_t model(bit right, bit dw, bit big, logic [AW-1:0] a, logic [63:0] d);
        exp_t e;
        int n, off, lm, step, cnt, ba, rb;
        n    = dw ? 8 : 4;
        off  = dw ? int'(a[2:0]) : int'(a[1:0]);
        lm   = big ? off : (off ^ (n - 1));          // R1
        step = big ? 1 : -1;                          // R4
        if (right) step = -step;
        cnt  = right ? lm + 1 : n - lm;               // R2 / R3
        e.addr = {a[AW-1:3], 3'b000};                 // R6
        e.be   = '0;
        e.data = '0;
        for (int j = 0; j < cnt; j++) begin
            rb = right ? j : n - 1 - j;
            ba = int'(a[2:0]) + step * j;
            e.be[ba] = 1'b1;
            e.data[ba*8 +: 8] = d[rb*8 +: 8];
        end
        if (right ? (lm == n - 1) : (lm == 0)) e.tag = "R8";
        else e.tag = right ? "R3" : "R2";
        return e;
    endfunction

    task automatic send(bit v, bit right, bit dw, bit big, logic [AW-1:0] a, logic [63:0] d);
        @(negedge clk);
        in_valid = v; in_right = right; in_dword = dw; in_big = big;
        in_addr = a; in_data = d;
        if (v) sb.push_back(model(right, dw, big, a, d));
    endtask

    // monitor: compares each produced beat against the oldest expected one
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                n_vec++;
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        n_bad++;
                        $display("FAIL R9: unexpected beat addr=%h be=%h exp=no beat", out_addr, out_be);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        if (out_addr !== e.addr) begin
                            n_bad++;
                            $display("FAIL R6: addr act=%h exp=%h", out_addr, e.addr);
                        end else if (out_be !== e.be) begin
                            n_bad++;
                            $display("FAIL %s/R1/R4/R5: be act=%h exp=%h", e.tag, out_be, e.be);
                        end else if (out_data !== e.data) begin
                            n_bad++;
                            $display("FAIL %s/R4/R7: data act=%h exp=%h", e.tag, out_data, e.data);
                        end
                    end
                end else if (out_be !== 8'h00 || out_data !== 64'h0 || out_addr !== '0) begin
                    n_bad++;
                    $display("FAIL R9: idle beat be=%h data=%h exp=0", out_be, out_data);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [63:0] pat;
        // R10: reset state
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_be !== 8'h00) begin
            n_bad++;
            $display("FAIL R10: reset valid=%b be=%h exp=0/00", out_valid, out_be);
        end
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // back to back, every offset, op, size and byte order
        pat = 64'h0102_0304_0506_0708;
        for (int big = 0; big < 2; big++)
            for (int dw = 0; dw < 2; dw++)
                for (int rt = 0; rt < 2; rt++)
                    for (int o = 0; o < 8; o++)
                        send(1'b1, rt[0], dw[0], big[0], {24'hA5C3_10, 5'(o * 3), 3'(o)}, pat);

        // R5: word ops with upper data noise must ignore data_in[63:32]
        for (int o = 0; o < 8; o++)
            send(1'b1, o[0], 1'b0, o[1], {29'h1234_567, 3'(o)}, 64'hDEAD_BEEF_CAFE_F00D);

        // idle slots interleaved with random requests (R9)
        for (int k = 0; k < 150; k++) begin
            if (k % 3 == 2) send(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
            else send(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), $urandom, {$urandom, $urandom});
        end

        send(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
        repeat (3) @(negedge clk);
        n_vec++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R9: beats missing act=%0d exp=0", sb.size());
        end
        finish_run();
    end

endmodule